// File: doc/BRIEF.md
# Pin Edge Wakeup Port

This block watches a group of input pins, normally eight lines wired to a key matrix. The pins idle high through pull-ups, and a key press pulls its line low for a short time. Each pin has its own sticky flag. The flag is set when the pin shows the selected edge, after the pin has been synchronized into the clock domain. A per-pin edge-select bit picks a falling or a rising edge. A build parameter can remove that register, and the port then reacts to falling edges only.

A per-pin enable mask decides which flags take part in the single interrupt output. A flag is recorded whether or not its enable bit is set. Software reads the flags over a small register bus and clears them by writing ones. If an edge arrives in the same cycle as the write that clears its flag, the edge wins.

Top module: `edge_wake_port`

## Requirements
- R1: After reset the enable mask, the flags and the edge selects read 0, `irq` is low, and the pin-level register reads all ones.
- R2: With edge-select bit 0 (the reset value), a high-to-low transition on a pin sets only that pin's flag. A low-to-high transition sets nothing.
- R3: With edge-select bit 1, a low-to-high transition sets only that pin's flag. A high-to-low transition sets nothing.
- R4: The register addresses are fixed. Address 0 is the enable mask (read/write). Address 1 is the flags (read, write-one-to-clear). Address 2 is the edge select (read/write). Address 3 is the synchronized pin levels (read-only). A pin change driven before rising clock edge k shows at address 3 after edge k+1, and in the flags after edge k+2.
- R5: Writing address 1 clears exactly the flags whose data bits are 1. Bits written as 0 leave their flags unchanged.
- R6: When an edge is detected on a pin in the same cycle as a clearing write to that pin's flag, the flag stays set.
- R7: `irq` is high exactly when some flag is set and its enable bit is 1. Flags are set even while their enable bit is 0.
- R8: With `HAS_POLARITY` = 0, address 2 always reads 0, writes to it have no effect, and only falling edges set flags.
- R9: A set flag stays set until it is cleared, even after its pin returns to its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register address |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | WIDTH | Write data |
| busRdData | output | WIDTH | Read data for `busAddr` (combinational) |
| pinIn | input | WIDTH | Asynchronous pin levels |
| irq | output | 1 | Combined masked interrupt request |

## Verification
A flag that was set from the wrong edge shows up on the flag read three clock edges after the pin moves. If the enable mask is not zero, it also raises `irq` in the same cycle. A stale edge-detect register produces a spurious flag on the first cycle after the synchronizer output changes. A bad clear mask shows on the read right after the write. The bench sweeps every pin through both polarities and every enable value against a fixed flag pattern, so a fault on any single bit is exposed within a few cycles of its stimulus.

// File: rtl/edge_wake_pkg.sv
package edge_wake_pkg;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_ENABLE   = 2'd0,
    SEL_FLAGS    = 2'd1,
    SEL_POLARITY = 2'd2,
    SEL_LEVEL    = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrEnable;
    logic wrFlags;
    logic wrPolarity;
  } ctlStrobes_t;
endpackage

// File: rtl/edge_wake_ctrl.sv
module edge_wake_ctrl
  import edge_wake_pkg::*;
(
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWrEn,
  output ctlStrobes_t           strobes,
  output regSel_e               readSel
);
  always_comb begin
    readSel            = regSel_e'(busAddr);
    strobes.wrEnable   = busWrEn && (readSel == SEL_ENABLE);
    strobes.wrFlags    = busWrEn && (readSel == SEL_FLAGS);
    strobes.wrPolarity = busWrEn && (readSel == SEL_POLARITY);
  end
endmodule

// File: rtl/edge_wake_datapath.sv
module edge_wake_datapath
  import edge_wake_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter bit HAS_POLARITY = 1'b1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  regSel_e          readSel,
  input  logic [WIDTH-1:0] busWrData,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] busRdData,
  output logic [WIDTH-1:0] flagVec,
  output logic [WIDTH-1:0] enVec,
  output logic [WIDTH-1:0] polVec,
  output logic [WIDTH-1:0] levelVec,
  output logic             irq
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][WIDTH-1:0] syncQ;
  logic [WIDTH-1:0] prevQ;
  logic [WIDTH-1:0] fallVec, riseVec, hitVec, clrMask;

  // Synchronizer chain; resets to the idle (pulled-up) level.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign levelVec = syncQ[LAST_STAGE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '1;
    else       prevQ <= levelVec;
  end

  generate
    if (HAS_POLARITY) begin : g_pol
      logic [WIDTH-1:0] polQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   polQ <= '0;
        else if (strobes.wrPolarity) polQ <= busWrData;
      end
      assign polVec = polQ;
    end else begin : g_fixed
      logic unusedWrPol;
      assign unusedWrPol = strobes.wrPolarity;
      assign polVec      = '0;
    end
  endgenerate

  always_comb begin
    fallVec = prevQ & ~levelVec;
    riseVec = ~prevQ & levelVec;
    hitVec  = (polVec & riseVec) | (~polVec & fallVec);
    clrMask = strobes.wrFlags ? busWrData : '0;
  end

  // New edges are ORed in after the clear, so an edge beats a same-cycle clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagVec <= '0;
    else       flagVec <= (flagVec & ~clrMask) | hitVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 enVec <= '0;
    else if (strobes.wrEnable) enVec <= busWrData;
  end

  assign irq = |(flagVec & enVec);

  always_comb begin
    unique case (readSel)
      SEL_ENABLE:   busRdData = enVec;
      SEL_FLAGS:    busRdData = flagVec;
      SEL_POLARITY: busRdData = polVec;
      default:      busRdData = levelVec;
    endcase
  end
endmodule

// File: rtl/edge_wake_port.sv
module edge_wake_port
  import edge_wake_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter bit HAS_POLARITY = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWrEn,
  input  logic [WIDTH-1:0]      busWrData,
  output logic [WIDTH-1:0]      busRdData,
  input  logic [WIDTH-1:0]      pinIn,
  output logic                  irq
);
  ctlStrobes_t      strobes;
  regSel_e          readSel;
  logic [WIDTH-1:0] flagVec, enVec, polVec, levelVec;

  edge_wake_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes),
    .readSel (readSel)
  );

  edge_wake_datapath #(
    .WIDTH        (WIDTH),
    .HAS_POLARITY (HAS_POLARITY),
    .SYNC_STAGES  (2)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .readSel   (readSel),
    .busWrData (busWrData),
    .pinIn     (pinIn),
    .busRdData (busRdData),
    .flagVec   (flagVec),
    .enVec     (enVec),
    .polVec    (polVec),
    .levelVec  (levelVec),
    .irq       (irq)
  );
endmodule

// File: rtl/edge_wake_chk.sv
module edge_wake_chk
  import edge_wake_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [REG_ADDR_W-1:0] busAddr,
  input logic                  busWrEn,
  input logic [WIDTH-1:0]      busWrData,
  input logic                  irq,
  input logic [WIDTH-1:0]      flagVec,
  input logic [WIDTH-1:0]      enVec,
  input logic [WIDTH-1:0]      polVec,
  input logic [WIDTH-1:0]      levelVec
);
  logic flagWr, enWr;
  assign flagWr = busWrEn && (busAddr == SEL_FLAGS);
  assign enWr   = busWrEn && (busAddr == SEL_ENABLE);

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(flagWr) |-> ((flagVec & $past(flagVec)) == $past(flagVec))); // R9

  AST_EDGE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    ((flagVec & ~$past(flagVec)) &
     ~(($past(polVec) & ~$past(levelVec, 2) & $past(levelVec)) |
       (~$past(polVec) & $past(levelVec, 2) & ~$past(levelVec)))) == '0); // R2

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    $past(flagWr) |->
      ((flagVec & $past(busWrData) & ~($past(levelVec) ^ $past(levelVec, 2))) == '0)); // R5

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(enWr) || ((flagVec & ~$past(flagVec)) != '0))); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (enVec != '0)); // R7
endmodule

bind edge_wake_port edge_wake_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .irq       (irq),
  .flagVec   (flagVec),
  .enVec     (enVec),
  .polVec    (polVec),
  .levelVec  (levelVec)
);

// File: tb/edge_wake_port_tb.sv
module edge_wake_port_tb;
  import edge_wake_pkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] pins = 8'hFF;
  logic [7:0] rdDut, rdFix;
  logic       irqDut, irqFix;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  edge_wake_port #(.WIDTH(8), .HAS_POLARITY(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rdDut), .pinIn(pins), .irq(irqDut));

  edge_wake_port #(.WIDTH(8), .HAS_POLARITY(1'b0)) u_fix (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rdFix), .pinIn(pins), .irq(irqFix));

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    busAddr = a;
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  // Drive pins, then wait past the flag update (third edge after the change).
  task automatic setPins(input logic [7:0] v);
    @(negedge clk);
    pins = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rd(SEL_ENABLE);   chk("R1", "enable", rdDut, 8'h00);
    rd(SEL_FLAGS);    chk("R1", "flags", rdDut, 8'h00);
    rd(SEL_POLARITY); chk("R1", "polarity", rdDut, 8'h00);
    rd(SEL_LEVEL);    chk("R1", "level", rdDut, 8'hFF);
    chk("R1", "irq", {7'd0, irqDut}, 8'h00);

    // R2 falling-edge sweep with R4 latency, R9 hold, R5 clear
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      b = 8'(1 << i);
      @(negedge clk); pins = ~b;
      @(posedge clk); @(posedge clk);
      #1 busAddr = SEL_FLAGS;
      #1 chk("R4", "flags before third edge", rdDut, 8'h00);
      busAddr = SEL_LEVEL;
      #1 chk("R4", "synced level", rdDut, ~b);
      @(posedge clk);
      rd(SEL_FLAGS); chk("R2", "falling sets own flag", rdDut, b);
      chk("R8", "fixed falling", rdFix, b);
      setPins(8'hFF);
      rd(SEL_FLAGS); chk("R9", "flag held after release", rdDut, b);
      wr(SEL_FLAGS, b);
      rd(SEL_FLAGS); chk("R5", "w1c single", rdDut, 8'h00);
    end

    // R3 rising-edge sweep; fixed variant ignores the polarity write (R8)
    wr(SEL_POLARITY, 8'hFF);
    rd(SEL_POLARITY); chk("R4", "polarity readback", rdDut, 8'hFF);
    chk("R8", "fixed polarity reads 0", rdFix, 8'h00);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      b = 8'(1 << i);
      setPins(~b);
      rd(SEL_FLAGS); chk("R3", "falling ignored", rdDut, 8'h00);
      chk("R8", "fixed falling", rdFix, b);
      setPins(8'hFF);
      rd(SEL_FLAGS); chk("R3", "rising sets own flag", rdDut, b);
      chk("R8", "fixed rising ignored", rdFix, b);
      wr(SEL_FLAGS, b);
    end

    // Mixed polarity pattern
    wr(SEL_POLARITY, 8'hA5);
    wr(SEL_FLAGS, 8'hFF);
    setPins(8'h00);
    rd(SEL_FLAGS); chk("R2", "mixed falling", rdDut, 8'h5A);
    setPins(8'hFF);
    rd(SEL_FLAGS); chk("R3", "mixed rising", rdDut, 8'hFF);
    wr(SEL_FLAGS, 8'hFF);
    setPins(8'h00);
    rd(SEL_FLAGS); chk("R2", "mixed pattern", rdDut, 8'h5A);
    chk("R8", "fixed all falling", rdFix, 8'hFF);

    // R7 exhaustive enable sweep against fixed flags
    for (int e = 0; e < 256; e++) begin
      wr(SEL_ENABLE, 8'(e));
      chk("R7", "irq dut", {7'd0, irqDut}, {7'd0, |(8'(e) & 8'h5A)});
      chk("R7", "irq fixed", {7'd0, irqFix}, {7'd0, (e != 0)});
    end
    wr(SEL_ENABLE, 8'h00);
    setPins(8'hFF);
    rd(SEL_FLAGS); chk("R7", "flags set with enable clear", rdDut, 8'hFF);
    rd(SEL_ENABLE); chk("R4", "enable readback", rdDut, 8'h00);

    // R5 partial clears
    wr(SEL_FLAGS, 8'h0F);
    rd(SEL_FLAGS); chk("R5", "partial clear", rdDut, 8'hF0);
    wr(SEL_FLAGS, 8'h00);
    rd(SEL_FLAGS); chk("R5", "zero write no effect", rdDut, 8'hF0);
    wr(SEL_FLAGS, 8'hFF);
    rd(SEL_FLAGS); chk("R5", "clear all", rdDut, 8'h00);

    // R6 edge coincident with clear
    wr(SEL_POLARITY, 8'h00);
    wr(SEL_FLAGS, 8'hFF);
    setPins(8'hFC);
    setPins(8'hFF);
    rd(SEL_FLAGS); chk("R6", "setup flags", rdDut, 8'h03);
    @(negedge clk); pins = 8'hFE;
    @(posedge clk); @(posedge clk);
    @(negedge clk); busAddr = SEL_FLAGS; busWrData = 8'h03; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk); busWrEn = 1'b0;
    rd(SEL_FLAGS); chk("R6", "edge beats clear", rdDut, 8'h01);
    chk("R6", "edge beats clear fixed", rdFix, 8'h01);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule